// File: doc/BRIEF.md
# Masked-field floating-point status register

This block owns the 32-bit floating-point status and control word and carries out a move into it under a field mask. An update presents a 64-bit source operand, an 8-bit field mask and a record flag together with a one-cycle valid strobe. The source's low 32-bit word is cut into eight 4-bit fields. Each field whose mask bit is set replaces the matching status field, and every other status field keeps its value.

Two bits of the top field are summary bits and are never taken from the source. The invalid-operation summary and the enabled-exception summary are always rebuilt from the bits they summarise. When the record flag is set, the block also reports the top four status bits, after the update, as a 4-bit condition field with a one-cycle valid flag.

Status bits are numbered big-endian: status bit 0 is `stat_o[31]` and status bit 31 is `stat_o[0]`. The block has no port toward the fixed-point exception register, so this operation can never write to it.

Top module: `fsx_unit`

## Requirements
- R1: While `rst_n` is low, `stat_o` reads 0, `cond_o` reads 0 and `cond_vld_o` reads 0.
- R2: Mask bit `7-i` selects status field i (status bits 4i..4i+3). That field takes source bits 32+4i..35+4i, which are `upd_src[31-4i -: 4]`. `upd_mask[7]` therefore loads `stat_o[31:28]` from `upd_src[31:28]`, and `upd_mask[0]` loads `stat_o[3:0]` from `upd_src[3:0]`.
- R3: Fields whose mask bit is clear keep their previous value. A mask of 0x00 leaves every non-summary bit unchanged.
- R4: Source bits `upd_src[63:32]` have no effect on any output.
- R5: Status bit 2, the invalid summary (`stat_o[29]`), always equals the OR of status bits 7–12 and 21–23. Any value written to it is discarded.
- R6: Status bit 1, the enabled summary (`stat_o[30]`), always equals the OR of five exception/enable pairs: (bit 2 & bit 24), (bit 3 & bit 25), (bit 4 & bit 26), (bit 5 & bit 27) and (bit 6 & bit 28). It uses the new bit 2. Any value written to it is discarded.
- R7: Status bit 0 (`stat_o[31]`) and status bit 3 (`stat_o[28]`) take the source value when field 0 is selected.
- R8: An update takes effect on the first rising edge that sees `upd_vld` high. With `upd_vld` low, `stat_o` holds.
- R9: An update with `upd_rec` high sets `cond_o` to the updated `stat_o[31:28]` on that same edge, ordered status bits 0,1,2,3 from MSB to LSB. It also raises `cond_vld_o` for one cycle.
- R10: On a cycle without a recorded update, `cond_o` holds its value and `cond_vld_o` is low.
- R11: Source low word 0x30003000 with mask 0x80 applied after reset gives status field 0 = 0001. Source low word 0x23200000 with mask 0xE0 then gives fields 0–2 = 0010 0011 0010 and a condition field of 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| upd_vld | input | 1 | One-cycle strobe that starts an update |
| upd_mask | input | 8 | Field mask, MSB selects status field 0 |
| upd_src | input | 64 | Source operand; only bits 31:0 are used |
| upd_rec | input | 1 | Record flag: produce the condition field |
| stat_o | output | 32 | Status register, status bit 0 at bit 31 |
| cond_o | output | 4 | Condition field copy of status bits 0–3 |
| cond_vld_o | output | 1 | Pulses with each recorded update |

## Verification
The hardest case to reach is a write that disagrees with the summary rules. Such a write sets a summary bit while clearing its sources, or clears a summary bit while an exception and its enable both stay set in fields it does not touch. The bench gets there by sweeping all 256 masks against several source patterns. These include all-ones, the bitwise complement of the current status and random words. As a result, enable fields left over from earlier writes meet freshly written exception fields in every combination, and the summaries have to be rebuilt against both old and new content.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  localparam int STAT_W  = 32;
  localparam int FIELD_W = 4;
  localparam int NUM_FLD = STAT_W / FIELD_W;

  // big-endian status bit k lives at vector index STAT_W-1-k
  localparam int IX_FX  = STAT_W - 1 - 0;
  localparam int IX_FEX = STAT_W - 1 - 1;
  localparam int IX_VX  = STAT_W - 1 - 2;
  localparam int IX_OX  = STAT_W - 1 - 3;
  localparam int IX_UX  = STAT_W - 1 - 4;
  localparam int IX_ZX  = STAT_W - 1 - 5;
  localparam int IX_XX  = STAT_W - 1 - 6;
  localparam int IX_VE  = STAT_W - 1 - 24;
  localparam int IX_OE  = STAT_W - 1 - 25;
  localparam int IX_UE  = STAT_W - 1 - 26;
  localparam int IX_ZE  = STAT_W - 1 - 27;
  localparam int IX_XE  = STAT_W - 1 - 28;

  function automatic logic [STAT_W-1:0] be_range(int lo, int hi);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int k = lo; k <= hi; k++) m[STAT_W-1-k] = 1'b1;
    return m;
  endfunction

  // invalid-operation sub-bits: status bits 7..12 and 21..23
  localparam logic [STAT_W-1:0] VX_SRC_MASK = be_range(7, 12) | be_range(21, 23);

  localparam logic [STAT_W-1:0] SUMMARY_MASK =
    (STAT_W'(1) << IX_FEX) | (STAT_W'(1) << IX_VX);
endpackage

// File: rtl/fsx_field_merge.sv
module fsx_field_merge #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int WORD_W    = NUM_FIELDS * FIELD_W
) (
  input  logic [WORD_W-1:0]     cur_i,
  input  logic [WORD_W-1:0]     wr_i,
  input  logic [NUM_FIELDS-1:0] mask_i,
  output logic [WORD_W-1:0]     merged_o
);
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam int HI = WORD_W - 1 - f * FIELD_W;
    assign merged_o[HI -: FIELD_W] =
      mask_i[NUM_FIELDS-1-f] ? wr_i[HI -: FIELD_W] : cur_i[HI -: FIELD_W];
  end
endmodule

// File: rtl/fsx_summary.sv
module fsx_summary
  import fsx_pkg::*;
(
  input  logic [STAT_W-1:0] stat_i,
  output logic              vx_o,
  output logic              fex_o
);
  localparam logic [STAT_W-1:0] FEX_USED =
    (STAT_W'(1) << IX_OX) | (STAT_W'(1) << IX_UX) | (STAT_W'(1) << IX_ZX) |
    (STAT_W'(1) << IX_XX) | (STAT_W'(1) << IX_VE) | (STAT_W'(1) << IX_OE) |
    (STAT_W'(1) << IX_UE) | (STAT_W'(1) << IX_ZE) | (STAT_W'(1) << IX_XE);

  logic unused_bits;
  assign unused_bits = ^(stat_i & ~(FEX_USED | VX_SRC_MASK));

  always_comb begin
    vx_o  = |(stat_i & VX_SRC_MASK);
    fex_o = (vx_o          & stat_i[IX_VE]) |
            (stat_i[IX_OX] & stat_i[IX_OE]) |
            (stat_i[IX_UX] & stat_i[IX_UE]) |
            (stat_i[IX_ZX] & stat_i[IX_ZE]) |
            (stat_i[IX_XX] & stat_i[IX_XE]);
  end
endmodule

// File: rtl/fsx_cond_out.sv
module fsx_cond_out #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rec_en_i,
  input  logic [FIELD_W-1:0] top_i,
  output logic [FIELD_W-1:0] cond_o,
  output logic               cond_vld_o
);
  logic [FIELD_W-1:0] cond_q;
  logic               vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cond_q <= '0;
    else if (rec_en_i) cond_q <= top_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rec_en_i;
  end

  assign cond_o     = cond_q;
  assign cond_vld_o = vld_q;
endmodule

// File: rtl/fsx_unit.sv
module fsx_unit
  import fsx_pkg::*;
#(
  parameter int SRC_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_vld,
  input  logic [NUM_FLD-1:0]         upd_mask,
  input  logic [SRC_W-1:0]           upd_src,
  input  logic                       upd_rec,
  output logic [STAT_W-1:0]          stat_o,
  output logic [FIELD_W-1:0]         cond_o,
  output logic                       cond_vld_o
);
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] merged;
  logic [STAT_W-1:0] stat_nxt;
  logic              vx_new;
  logic              fex_new;
  logic              unused_hi;

  assign unused_hi = ^upd_src[SRC_W-1:STAT_W];

  fsx_field_merge #(.NUM_FIELDS(NUM_FLD), .FIELD_W(FIELD_W)) u_merge (
    .cur_i    (stat_q),
    .wr_i     (upd_src[STAT_W-1:0]),
    .mask_i   (upd_mask),
    .merged_o (merged)
  );

  fsx_summary u_sum (
    .stat_i (merged),
    .vx_o   (vx_new),
    .fex_o  (fex_new)
  );

  always_comb begin
    stat_nxt         = merged;
    stat_nxt[IX_VX]  = vx_new;
    stat_nxt[IX_FEX] = fex_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (upd_vld) stat_q <= stat_nxt;
  end

  fsx_cond_out #(.FIELD_W(FIELD_W)) u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .rec_en_i   (upd_vld & upd_rec),
    .top_i      (stat_nxt[STAT_W-1 -: FIELD_W]),
    .cond_o     (cond_o),
    .cond_vld_o (cond_vld_o)
  );

  assign stat_o = stat_q;
endmodule

// File: rtl/fsx_unit_chk.sv
module fsx_unit_chk
  import fsx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               upd_vld,
  input logic [NUM_FLD-1:0] upd_mask,
  input logic [FIELD_W-1:0] src_top,
  input logic               upd_rec,
  input logic [STAT_W-1:0]  stat_o,
  input logic [FIELD_W-1:0] cond_o,
  input logic               cond_vld_o
);
  logic [STAT_W-1:0] sel_bits;
  for (genvar f = 0; f < NUM_FLD; f++) begin : g_x
    assign sel_bits[STAT_W-1-f*FIELD_W -: FIELD_W] = {FIELD_W{upd_mask[NUM_FLD-1-f]}};
  end

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_vld |=> $stable(stat_o));

  // R3
  a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |=> (((stat_o ^ $past(stat_o)) & ~$past(sel_bits) & ~SUMMARY_MASK) == '0));

  // R7
  a_r7_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && upd_mask[NUM_FLD-1]) |=>
      (stat_o[IX_FX] == $past(src_top[FIELD_W-1]) && stat_o[IX_OX] == $past(src_top[0])));

  // R5
  a_r5_vx: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[IX_VX] == |(stat_o & VX_SRC_MASK));

  // R6
  a_r6_fex: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[IX_FEX] == ((stat_o[IX_VX] & stat_o[IX_VE]) | (stat_o[IX_OX] & stat_o[IX_OE]) |
                       (stat_o[IX_UX] & stat_o[IX_UE]) | (stat_o[IX_ZX] & stat_o[IX_ZE]) |
                       (stat_o[IX_XX] & stat_o[IX_XE])));

  // R9
  a_r9_rec: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && upd_rec) |=> (cond_vld_o && cond_o == stat_o[STAT_W-1 -: FIELD_W]));

  // R10
  a_r10_norec: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_vld && upd_rec) |=> (!cond_vld_o && $stable(cond_o)));
endmodule

bind fsx_unit fsx_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_vld    (upd_vld),
  .upd_mask   (upd_mask),
  .src_top    (upd_src[31:28]),
  .upd_rec    (upd_rec),
  .stat_o     (stat_o),
  .cond_o     (cond_o),
  .cond_vld_o (cond_vld_o)
);

// File: tb/test_fsx_unit.sv
`timescale 1ns/1ps
module test_fsx_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_vld;
  logic [7:0]  upd_mask;
  logic [63:0] upd_src;
  logic        upd_rec;
  logic [31:0] stat_o;
  logic [3:0]  cond_o;
  logic        cond_vld_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] exp_stat;
  logic [3:0]  exp_cond;

  always #2.5 clk = ~clk;

  fsx_unit i_fsx_unit (
    .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .upd_mask(upd_mask),
    .upd_src(upd_src), .upd_rec(upd_rec), .stat_o(stat_o),
    .cond_o(cond_o), .cond_vld_o(cond_vld_o)
  );

  function automatic logic bb(logic [31:0] s, int k);
    return s[31-k];
  endfunction

  function automatic logic [31:0] model(logic [31:0] cur, logic [31:0] lo, logic [7:0] m);
    logic [31:0] r;
    logic vx, fex;
    r = cur;
    for (int f = 0; f < 8; f++)
      if (m[7-f]) r[31-4*f -: 4] = lo[31-4*f -: 4];
    vx = 1'b0;
    for (int k = 7; k <= 12; k++) vx |= bb(r, k);
    for (int k = 21; k <= 23; k++) vx |= bb(r, k);
    fex = (vx & bb(r, 24)) | (bb(r, 3) & bb(r, 25)) | (bb(r, 4) & bb(r, 26)) |
          (bb(r, 5) & bb(r, 27)) | (bb(r, 6) & bb(r, 28));
    r[31-2] = vx;
    r[31-1] = fex;
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic upd(logic [7:0] m, logic [63:0] s, logic r, string req);
    @(negedge clk);
    upd_vld = 1'b1; upd_mask = m; upd_src = s; upd_rec = r;
    @(negedge clk);
    upd_vld = 1'b0;
    exp_stat = model(exp_stat, s[31:0], m);
    chk(stat_o === exp_stat, req, stat_o, exp_stat);
    if (r) begin
      exp_cond = exp_stat[31:28];
      chk(cond_vld_o === 1'b1 && cond_o === exp_cond, "R9",
          {27'd0, cond_vld_o, cond_o}, {27'd0, 1'b1, exp_cond});
    end else begin
      chk(cond_vld_o === 1'b0 && cond_o === exp_cond, "R10",
          {27'd0, cond_vld_o, cond_o}, {27'd0, 1'b0, exp_cond});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; upd_vld = 1'b0; upd_mask = 8'hFF; upd_src = '1; upd_rec = 1'b1;
    exp_stat = '0; exp_cond = '0;
    repeat (3) @(negedge clk);
    chk(stat_o === 32'h0 && cond_o === 4'h0 && cond_vld_o === 1'b0, "R1",
        {stat_o[31:5], cond_vld_o, cond_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 worked examples
    upd(8'h80, {32'hDEAD_BEEF, 32'h3000_3000}, 1'b0, "R11");
    chk(stat_o === 32'h1000_0000, "R11", stat_o, 32'h1000_0000);
    upd(8'hE0, {32'h0, 32'h2320_0000}, 1'b1, "R11");
    chk(stat_o === 32'h2320_0000 && cond_o === 4'h2, "R11",
        stat_o, 32'h2320_0000);

    // R2 single-field placement
    for (int f = 0; f < 8; f++)
      upd(8'h80 >> f, {32'h0, 32'h5555_5555}, 1'b0, "R2");

    // R4 high word ignored
    upd(8'hFF, {32'hFFFF_FFFF, 32'h0}, 1'b1, "R4");
    chk(stat_o === 32'h0, "R4", stat_o, 32'h0);

    // R8 no strobe, garbage on inputs
    @(negedge clk);
    upd_mask = 8'hFF; upd_src = '1; upd_rec = 1'b1;
    repeat (3) @(negedge clk);
    chk(stat_o === exp_stat, "R8", stat_o, exp_stat);
    chk(cond_vld_o === 1'b0 && cond_o === exp_cond, "R10",
        {31'd0, cond_vld_o}, 32'h0);

    // R5 R6 R3 R7: sweep every mask against several patterns
    for (int m = 0; m < 256; m++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] lo;
        case (p)
          0: lo = $urandom;
          1: lo = ~exp_stat;
          2: lo = 32'hFFFF_FFFF;
          default: lo = $urandom & $urandom;
        endcase
        upd(8'(m), {$urandom, lo}, logic'(p[0] ^ m[0]),
            (m == 0) ? "R3" : (p == 1 ? "R5" : (p == 2 ? "R6" : "R7")));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule